// File: doc/BRIEF.md
# Branch Source Trace Queue

This block keeps a short history of where the program most recently branched from. Each branch event reported while tracing is switched on pushes the low 28 bits of the branch-source address onto the front of an eight-slot queue. The older slots move back by one place, and the oldest slot is dropped once the queue is full. Each slot has its own valid flag alongside the address.

Software drains the history through a single read-only word port. A read request returns the newest slot as a 32-bit word: the valid flag in bit 31, zeros in bits 30 to 28, and the address in bits 27 to 0. The read consumes that slot. The remaining slots then move one place toward the front, and the slot left empty at the back becomes invalid. Successive reads therefore walk from newer branches to older ones.

Three events clear the valid flags: a synchronous power-on reset, a read (for the slot it consumes), and the rising edge of the trace enable (for all slots). The stored address bits are never reset, so an invalid slot may return any address.

Top module: `branch_trace_queue`

## Requirements
- R1: When `br_valid` is high, `trace_en` is high and the cycle is not the enable's first high cycle, the branch is captured. The next read returns bit 31 = 1 and bits 27:0 equal to `br_pc[27:0]`.
- R2: The queue holds eight entries. After more than eight captures, eight reads return the eight most recent addresses newest first, and the ninth read returns bit 31 = 0.
- R3: A read (`rd_req` high at a clock edge) loads `rd_data` at that edge with the newest entry, with bits 30:28 always 0. The remaining entries then move one place toward the front.
- R4: The entry vacated at the back by a read is invalid. Once every captured entry has been read, further reads return bit 31 = 0.
- R5: When a read and a capture fall in the same cycle, the read returns the newest entry from before the capture. The captured address becomes the new newest entry, and the older entries keep their order.
- R6: Branch events while `trace_en` is low are not captured. Reads still operate normally while tracing is off.
- R7: In the first cycle that `trace_en` is high after being low, all valid flags are cleared and a branch event in that same cycle is not captured.
- R8: While `rst_n` is low at a clock edge, all valid flags and `rd_data` are cleared to 0.
- R9: Bits 31:28 of `br_pc` are discarded and never appear in `rd_data`.
- R10: `rd_data` keeps its value in cycles without a read, even across captures.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| trace_en | input | 1 | Trace enable; its rising edge clears all valid flags |
| br_valid | input | 1 | Branch event strobe, one per cycle |
| br_pc | input | 32 | Branch-source instruction address |
| rd_req | input | 1 | Read request; consumes the newest entry |
| rd_data | output | 32 | Last word read: {valid, 3'b000, address[27:0]} |

## Verification
The hardest state to reach is a read and a capture landing in the same clock edge. From the ports this looks the same as a read followed by a capture, unless the queue already holds older entries whose order can be seen afterwards. The bench therefore fills two entries first, then drives `rd_req` and `br_valid` together on one edge. It then drains the queue and checks the exact newest-first order, including the empty read at the end. The enable's first-cycle clear is reached the same way. A branch is driven in the very cycle `trace_en` rises, and a drain then shows that neither the earlier entries nor that branch survived.

// File: rtl/bt_pkg.sv
// Package: shared types for the branch source trace queue.
// Assumes the stored address field is fixed at 28 bits and the read word at 32 bits.
package bt_pkg;
    localparam int TRACE_ADDR_W = 28;
    localparam int WORD_W       = 32;
    localparam int RSVD_W       = WORD_W - 1 - TRACE_ADDR_W;

    // One queue slot: valid flag plus stored address.
    typedef struct packed {
        logic                    vld;
        logic [TRACE_ADDR_W-1:0] addr;
    } bt_entry_t;

    // Per-slot update choice for one clock edge.
    typedef enum logic [1:0] {
        SLOT_HOLD = 2'd0,
        SLOT_PREV = 2'd1,
        SLOT_NEXT = 2'd2
    } slot_mode_e;
endpackage

// File: rtl/bt_enable_edge.sv
// Module: bt_enable_edge
// Detects the first high cycle of the trace enable and gates branch capture.
// Assumes trace_en is synchronous to clk. Capture is suppressed in the rising cycle.
module bt_enable_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic trace_en,
    input  logic br_valid,
    output logic en_rise,
    output logic push
);
    logic en_q;

    // Remember last cycle's enable to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= trace_en;
    end

    // Rising edge and gated capture strobe.
    always_comb begin
        en_rise = trace_en & ~en_q;
        push    = br_valid & trace_en & ~en_rise;
    end

    // A rising edge cannot repeat in the following cycle (R7).
    assert_single_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        en_rise |=> !en_rise);

    // No capture while tracing is off (R6).
    assert_no_push_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !trace_en |-> !push);
endmodule

// File: rtl/bt_slot.sv
// Module: bt_slot
// One queue slot. It takes its neighbour toward the front on a capture and its
// neighbour toward the back on a read. It holds when both happen, except the
// front slot, which takes the new address.
// Assumes the address bits need no reset; only the valid flag is reset.
module bt_slot
    import bt_pkg::*;
#(
    parameter bit IS_FRONT = 1'b0
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  logic      pop,
    input  logic      clr,
    input  bt_entry_t from_prev,
    input  bt_entry_t from_next,
    output bt_entry_t q
);
    slot_mode_e mode;
    bt_entry_t  nxt;

    // Select where this slot's next content comes from.
    always_comb begin
        if (IS_FRONT) begin
            if (push)     mode = SLOT_PREV;
            else if (pop) mode = SLOT_NEXT;
            else          mode = SLOT_HOLD;
        end else begin
            if (push && pop) mode = SLOT_HOLD;
            else if (push)   mode = SLOT_PREV;
            else if (pop)    mode = SLOT_NEXT;
            else             mode = SLOT_HOLD;
        end
        case (mode)
            SLOT_PREV: nxt = from_prev;
            SLOT_NEXT: nxt = from_next;
            default:   nxt = q;
        endcase
    end

    // Address storage, deliberately without reset.
    always_ff @(posedge clk) begin
        q.addr <= nxt.addr;
    end

    // Valid flag with reset and enable clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   q.vld <= 1'b0;
        else if (clr) q.vld <= 1'b0;
        else          q.vld <= nxt.vld;
    end

    // Clearing leaves the slot invalid (R7, R8).
    assert_clr_invalid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !q.vld);
endmodule

// File: rtl/bt_read_port.sv
// Module: bt_read_port
// Registers the newest entry as a 32-bit word on each read request.
// Assumes the word layout {valid, reserved zeros, address}.
module bt_read_port
    import bt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  bt_entry_t         front,
    output logic [WORD_W-1:0] rd_data
);
    // Load the read word on a request, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_req) rd_data <= {front.vld, {RSVD_W{1'b0}}, front.addr};
    end

    // Reserved bits always read as zero (R3).
    assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[WORD_W-2:TRACE_ADDR_W] == '0);

    // Without a request the word holds (R10).
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(rd_data));
endmodule

// File: rtl/branch_trace_queue.sv
// Module: branch_trace_queue (top)
// An eight-deep branch-source history with a clear-on-read word port.
// Assumes one branch event at most per cycle and a synchronous reset.
module branch_trace_queue
    import bt_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PC_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trace_en,
    input  logic              br_valid,
    input  logic [PC_W-1:0]   br_pc,
    input  logic              rd_req,
    output logic [WORD_W-1:0] rd_data
);
    localparam int LAST = DEPTH - 1;

    logic            en_rise;
    logic            push;
    bt_entry_t       slot_q    [DEPTH];
    bt_entry_t       slot_prev [DEPTH];
    bt_entry_t       slot_next [DEPTH];
    logic [DEPTH-1:0] vld_vec;

    bt_enable_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .trace_en (trace_en),
        .br_valid (br_valid),
        .en_rise  (en_rise),
        .push     (push)
    );

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_slot
            // Neighbour wiring: new address in front, invalid filler at the back.
            if (gi == 0) begin : g_front
                assign slot_prev[gi] = '{vld: 1'b1, addr: br_pc[TRACE_ADDR_W-1:0]};
            end else begin : g_mid
                assign slot_prev[gi] = slot_q[gi-1];
            end
            if (gi == LAST) begin : g_back
                assign slot_next[gi] = '{vld: 1'b0, addr: slot_q[gi].addr};
            end else begin : g_inner
                assign slot_next[gi] = slot_q[gi+1];
            end

            bt_slot #(.IS_FRONT(gi == 0)) u_slot (
                .clk       (clk),
                .rst_n     (rst_n),
                .push      (push),
                .pop       (rd_req),
                .clr       (en_rise),
                .from_prev (slot_prev[gi]),
                .from_next (slot_next[gi]),
                .q         (slot_q[gi])
            );

            assign vld_vec[gi] = slot_q[gi].vld;

            // Valid entries form a contiguous run from the front (R2, R4).
            if (gi > 0) begin : g_prefix
                assert_prefix_R4: assert property (@(posedge clk) disable iff (!rst_n)
                    vld_vec[gi] |-> vld_vec[gi-1]);
            end
        end
    endgenerate

    bt_read_port u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_req  (rd_req),
        .front   (slot_q[0]),
        .rd_data (rd_data)
    );

    // A capture leaves a valid newest entry holding the low address bits (R1, R9).
    assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (slot_q[0].vld && slot_q[0].addr == $past(br_pc[TRACE_ADDR_W-1:0])));

    // The enable's rising edge empties the queue (R7).
    assert_enable_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        en_rise |=> (vld_vec == '0));

    // A read without a capture vacates the back slot (R4).
    assert_back_vacated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !push) |=> !vld_vec[LAST]);

    // The read word reflects the newest flag from before the edge (R3, R5).
    assert_read_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> (rd_data[WORD_W-1] == $past(vld_vec[0])));
endmodule

// File: tb/branch_trace_queue_tb_top.sv
module branch_trace_queue_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trace_en = 1'b0;
    logic        br_valid = 1'b0;
    logic [31:0] br_pc = '0;
    logic        rd_req = 1'b0;
    logic [31:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [31:0] FULL = 32'hFFFF_FFFF;
    localparam logic [31:0] FLAG = 32'hF000_0000;  // flag and reserved bits only

    always #10 clk = ~clk;  // 50 MHz

    branch_trace_queue dut_i (
        .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .br_valid(br_valid),
        .br_pc(br_pc), .rd_req(rd_req), .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input logic [31:0] mask);
        checks++;
        if ((act & mask) !== (exp & mask)) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h mask=%h", req, act, exp, mask);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic branch(input logic [31:0] pc);
        br_valid = 1'b1; br_pc = pc;
        @(negedge clk);
        br_valid = 1'b0;
    endtask

    task automatic do_read(output logic [31:0] w);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        w = rd_data;
    endtask

    task automatic drain();
        logic [31:0] w;
        for (int i = 0; i < 8; i++) do_read(w);
    endtask

    task automatic t_reset();
        logic [31:0] w;
        rst_n = 1'b0; idle(3);
        chk("R8 rd_data after reset", rd_data, 32'h0, FULL);
        rst_n = 1'b1; trace_en = 1'b1; idle(2);
        do_read(w);
        chk("R8 queue empty after reset", w, 32'h0, FLAG);
    endtask

    task automatic t_basic();
        logic [31:0] w;
        branch(32'h0000_1110); branch(32'h0222_2220); branch(32'h0333_3330);
        do_read(w); chk("R1 R3 newest", w, 32'h8333_3330, FULL);
        do_read(w); chk("R3 second", w, 32'h8222_2220, FULL);
        do_read(w); chk("R3 third", w, 32'h8000_1110, FULL);
        do_read(w); chk("R4 empty after drain", w, 32'h0, FLAG);
    endtask

    task automatic t_upper();
        logic [31:0] w;
        branch(32'hF123_4567);
        do_read(w); chk("R9 upper bits dropped", w, 32'h8123_4567, FULL);
    endtask

    task automatic t_overflow();
        logic [31:0] w;
        for (int i = 0; i < 10; i++) branch(32'h0000_0100 + 32'(i * 16));
        for (int i = 9; i >= 2; i--) begin
            do_read(w);
            chk("R2 overflow order", w, 32'h8000_0100 + 32'(i * 16), FULL);
        end
        do_read(w); chk("R2 ninth read invalid", w, 32'h0, FLAG);
    endtask

    task automatic t_disabled();
        logic [31:0] w;
        branch(32'h0AAA_0000);
        trace_en = 1'b0; idle(1);
        branch(32'h0BBB_0000);
        do_read(w); chk("R6 disabled branch ignored", w, 32'h8AAA_0000, FULL);
        do_read(w); chk("R6 nothing captured", w, 32'h0, FLAG);
        trace_en = 1'b1; idle(2);
    endtask

    task automatic t_same_cycle();
        logic [31:0] w;
        branch(32'h0000_00A0); branch(32'h0000_00B0);
        br_valid = 1'b1; br_pc = 32'h0000_00C0; rd_req = 1'b1;
        @(negedge clk);
        br_valid = 1'b0; rd_req = 1'b0;
        chk("R5 read returns pre-branch newest", rd_data, 32'h8000_00B0, FULL);
        do_read(w); chk("R5 new entry is newest", w, 32'h8000_00C0, FULL);
        do_read(w); chk("R5 older entry kept", w, 32'h8000_00A0, FULL);
        do_read(w); chk("R5 then empty", w, 32'h0, FLAG);
    endtask

    task automatic t_enable_clear();
        logic [31:0] w;
        branch(32'h0000_0D00); branch(32'h0000_0E00);
        trace_en = 1'b0; idle(1);
        trace_en = 1'b1; br_valid = 1'b1; br_pc = 32'h0000_0F00;
        @(negedge clk);
        br_valid = 1'b0;
        do_read(w); chk("R7 flags cleared, rising-cycle branch dropped", w, 32'h0, FLAG);
        branch(32'h0000_0123);
        do_read(w); chk("R7 capture resumes", w, 32'h8000_0123, FULL);
    endtask

    task automatic t_hold();
        logic [31:0] w;
        branch(32'h0555_5550);
        do_read(w); chk("R10 read value", w, 32'h8555_5550, FULL);
        idle(3); branch(32'h0666_6660); idle(2);
        chk("R10 rd_data held", rd_data, 32'h8555_5550, FULL);
        drain();
    endtask

    task automatic t_mid_reset();
        logic [31:0] w;
        branch(32'h0777_0000); branch(32'h0888_0000);
        rst_n = 1'b0; idle(1);
        chk("R8 rd_data cleared mid-run", rd_data, 32'h0, FULL);
        rst_n = 1'b1; idle(1);
        do_read(w); chk("R8 flags cleared mid-run", w, 32'h0, FLAG);
    endtask

    initial begin
        idle(1);
        t_reset();
        t_basic();
        t_upper();
        t_overflow();
        t_disabled();
        t_same_cycle();
        t_enable_clear();
        t_hold();
        t_mid_reset();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule